// File: doc/BRIEF.md
# Load-Use Interlock

This block sits beside the decode stage of a five-stage in-order pipeline. Each cycle it looks at the up to two source registers of the instruction in decode and at the instruction one stage ahead, in execute. If that older instruction is a load, and its destination is a register the decode instruction actually reads, the forwarding network cannot supply the value in time. The block then freezes the front end for one cycle.

The decision is purely combinational and is qualified on both sides:

- A source only counts when its use flag is set.
- A destination only counts when the producer really writes a register.
- Register zero never creates a hazard.

During a stall the program counter and the fetch/decode pipeline register keep their contents. The control word entering execute is swapped for a no-operation. On the next cycle the load has moved on, the bubble sits in execute, and forwarding takes over.

Top module: `load_use_interlock`

## Requirements
- R1: When execute holds a load (`ex_mem_rd`=1, `ex_reg_wr`=1) whose 5-bit destination equals nonzero `dec_src1` and `dec_use1`=1, a stall is raised.
- R2: When execute holds a load whose destination equals nonzero `dec_src2` and `dec_use2`=1, a stall is raised.
- R3: A destination match produces no stall when `ex_reg_wr`=0, even if `ex_mem_rd`=1.
- R4: A match on a source whose use flag is 0 produces no stall.
- R5: Register number 0 never produces a stall, whatever the flags.
- R6: A producer that is not a load (`ex_mem_rd`=0) never produces a stall; forwarding covers it.
- R7: While stalling, `pc_wr_en`=0, `dec_latch_en`=0 and `ctl_bubble`=1. Otherwise `pc_wr_en`=1, `dec_latch_en`=1 and `ctl_bubble`=0.
- R8: A stall lasts one cycle per load-use pair. Once the inserted bubble (no register write, no load) occupies execute while the same instruction stays in decode, no stall is raised.
- R9: When both sources match the same load destination, the outputs are the same single stall as for one match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src1 | input | 5 | First source register number of the decode instruction |
| dec_use1 | input | 1 | Decode instruction reads its first source |
| dec_src2 | input | 5 | Second source register number of the decode instruction |
| dec_use2 | input | 1 | Decode instruction reads its second source |
| ex_dst | input | 5 | Destination register of the execute instruction |
| ex_reg_wr | input | 1 | Execute instruction writes a register |
| ex_mem_rd | input | 1 | Execute instruction reads data memory (load) |
| pc_wr_en | output | 1 | Program counter update enable |
| dec_latch_en | output | 1 | Fetch/decode pipeline register update enable |
| ctl_bubble | output | 1 | Select a no-operation control word into execute |

## Verification
The two source comparisons can fire in the same cycle. So can one comparison that counts and another that a cleared use flag or register zero should mask. The bench provokes both cases directly: it sets both sources to the load destination, and it pairs a live match on one operand with a masked match on the other. Random stimulus draws register numbers from a narrow range so that such coincidences recur often. In every case the three outputs must show exactly one stall when at least one qualified match exists, and none otherwise.

// File: rtl/lui_pkg.sv
package lui_pkg;

  // Front-end control produced by the interlock.
  typedef struct packed {
    logic pc_wr;
    logic dec_wr;
    logic bubble;
  } lui_ctl_t;

  function automatic lui_ctl_t lui_ctl_from_stall(input logic stall);
    lui_ctl_t c;
    c.pc_wr  = ~stall;
    c.dec_wr = ~stall;
    c.bubble = stall;
    return c;
  endfunction

endpackage

// File: rtl/lui_src_match.sv
module lui_src_match #(
  parameter int REG_W     = 5,
  parameter bit SKIP_ZERO = 1'b1
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic [REG_W-1:0] dst,
  output logic             hit
);

  logic same;
  logic live;

  always_comb begin
    same = (src == dst);
    if (SKIP_ZERO) begin
      live = used && (src != '0);
    end else begin
      live = used;
    end
    hit = same && live;
  end

endmodule

// File: rtl/lui_producer_qual.sv
module lui_producer_qual (
  input  logic reg_wr,
  input  logic mem_rd,
  output logic late_value
);

  // A value is late only when the producer loads it into a register.
  always_comb begin
    late_value = reg_wr && mem_rd;
  end

endmodule

// File: rtl/lui_stall_drive.sv
module lui_stall_drive
  import lui_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] hits,
  input  logic               late_value,
  output lui_ctl_t           ctl
);

  logic stall;

  always_comb begin
    stall = late_value && (|hits);
    ctl   = lui_ctl_from_stall(stall);
  end

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import lui_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter bit SKIP_ZERO = 1'b1
) (
  input  logic [REG_W-1:0] dec_src1,
  input  logic             dec_use1,
  input  logic [REG_W-1:0] dec_src2,
  input  logic             dec_use2,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_reg_wr,
  input  logic             ex_mem_rd,
  output logic             pc_wr_en,
  output logic             dec_latch_en,
  output logic             ctl_bubble
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] src_vec;
  logic [NUM_SRC-1:0]            use_vec;
  logic [NUM_SRC-1:0]            hit_vec;
  logic                          late_value;
  lui_ctl_t                      ctl;

  always_comb begin
    src_vec[0] = dec_src1;
    src_vec[1] = dec_src2;
    use_vec[0] = dec_use1;
    use_vec[1] = dec_use2;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    lui_src_match #(
      .REG_W    (REG_W),
      .SKIP_ZERO(SKIP_ZERO)
    ) u_match (
      .src (src_vec[i]),
      .used(use_vec[i]),
      .dst (ex_dst),
      .hit (hit_vec[i])
    );
  end

  lui_producer_qual u_qual (
    .reg_wr    (ex_reg_wr),
    .mem_rd    (ex_mem_rd),
    .late_value(late_value)
  );

  lui_stall_drive #(
    .NUM_SRC(NUM_SRC)
  ) u_drive (
    .hits      (hit_vec),
    .late_value(late_value),
    .ctl       (ctl)
  );

  always_comb begin
    pc_wr_en     = ctl.pc_wr;
    dec_latch_en = ctl.dec_wr;
    ctl_bubble   = ctl.bubble;
  end

endmodule

// File: rtl/lui_check.sv
module lui_check #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] dec_src1,
  input logic             dec_use1,
  input logic [REG_W-1:0] dec_src2,
  input logic             dec_use2,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_reg_wr,
  input logic             ex_mem_rd,
  input logic             pc_wr_en,
  input logic             dec_latch_en,
  input logic             ctl_bubble
);

  logic a_live;
  logic b_live;

  always_comb begin
    a_live = dec_use1 && (dec_src1 == ex_dst) && (dec_src1 != '0);
    b_live = dec_use2 && (dec_src2 == ex_dst) && (dec_src2 != '0);

    assert_front_end_agree_R7: assert (pc_wr_en == dec_latch_en)
      else $error("front-end enables disagree");
    assert_bubble_opposes_hold_R7: assert (ctl_bubble == !pc_wr_en)
      else $error("bubble not paired with hold");
    if (ex_mem_rd && ex_reg_wr && a_live) begin
      assert_src1_stall_R1: assert (ctl_bubble)
        else $error("missed stall on first source");
    end
    if (ex_mem_rd && ex_reg_wr && b_live) begin
      assert_src2_stall_R2: assert (ctl_bubble)
        else $error("missed stall on second source");
    end
    if (!ex_reg_wr) begin
      assert_no_write_no_stall_R3: assert (!ctl_bubble)
        else $error("stall without register write");
    end
    if (ctl_bubble) begin
      assert_stall_needs_used_src_R4: assert (a_live || b_live)
        else $error("stall without a used matching source");
    end
    if (ex_dst == '0) begin
      assert_zero_reg_quiet_R5: assert (!ctl_bubble)
        else $error("stall on register zero");
    end
    if (!ex_mem_rd) begin
      assert_non_load_quiet_R6: assert (!ctl_bubble)
        else $error("stall on non-load producer");
    end
  end

endmodule

bind load_use_interlock lui_check #(.REG_W(REG_W)) u_lui_check (
  .dec_src1    (dec_src1),
  .dec_use1    (dec_use1),
  .dec_src2    (dec_src2),
  .dec_use2    (dec_use2),
  .ex_dst      (ex_dst),
  .ex_reg_wr   (ex_reg_wr),
  .ex_mem_rd   (ex_mem_rd),
  .pc_wr_en    (pc_wr_en),
  .dec_latch_en(dec_latch_en),
  .ctl_bubble  (ctl_bubble)
);

// File: tb/sim_load_use_interlock.sv
`timescale 1ns/1ps
module sim_load_use_interlock;

  logic       clk;
  logic       rst_n;
  logic [4:0] dec_src1, dec_src2, ex_dst;
  logic       dec_use1, dec_use2, ex_reg_wr, ex_mem_rd;
  logic       pc_wr_en, dec_latch_en, ctl_bubble;
  int         checks;
  int         errors;
  bit         done;

  load_use_interlock u0 (
    .dec_src1    (dec_src1),
    .dec_use1    (dec_use1),
    .dec_src2    (dec_src2),
    .dec_use2    (dec_use2),
    .ex_dst      (ex_dst),
    .ex_reg_wr   (ex_reg_wr),
    .ex_mem_rd   (ex_mem_rd),
    .pc_wr_en    (pc_wr_en),
    .dec_latch_en(dec_latch_en),
    .ctl_bubble  (ctl_bubble)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit model_stall(
    input logic [4:0] s1, input logic u1,
    input logic [4:0] s2, input logic u2,
    input logic [4:0] d,  input logic rw, input logic mr);
    bit h1;
    bit h2;
    h1 = u1 && (s1 == d) && (s1 != 5'd0);
    h2 = u2 && (s2 == d) && (s2 != 5'd0);
    return rw && mr && (h1 || h2);
  endfunction

  task automatic apply(
    input logic [4:0] s1, input logic u1,
    input logic [4:0] s2, input logic u2,
    input logic [4:0] d,  input logic rw, input logic mr);
    @(negedge clk);
    dec_src1  = s1;
    dec_use1  = u1;
    dec_src2  = s2;
    dec_use2  = u2;
    ex_dst    = d;
    ex_reg_wr = rw;
    ex_mem_rd = mr;
    #2;
  endtask

  task automatic check(input string req, input bit exp_stall);
    checks++;
    if ({pc_wr_en, dec_latch_en, ctl_bubble} !== {~exp_stall, ~exp_stall, exp_stall}) begin
      errors++;
      $display("FAIL %s pc=%b dec=%b bub=%b expected pc=%b dec=%b bub=%b",
               req, pc_wr_en, dec_latch_en, ctl_bubble,
               ~exp_stall, ~exp_stall, exp_stall);
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    seed   = 32'd1234;
    void'($urandom(seed));
    apply(5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    check("reset idle R7", 1'b0);
    rst_n = 1'b1;

    apply(5'd3, 1'b1, 5'd7, 1'b1, 5'd3, 1'b1, 1'b1);
    check("R1 src1 load-use", 1'b1);
    check("R7 stall outputs", 1'b1);
    apply(5'd9, 1'b1, 5'd12, 1'b1, 5'd12, 1'b1, 1'b1);
    check("R2 src2 load-use", 1'b1);
    apply(5'd5, 1'b1, 5'd5, 1'b1, 5'd5, 1'b0, 1'b1);
    check("R3 no register write", 1'b0);
    apply(5'd6, 1'b0, 5'd2, 1'b1, 5'd6, 1'b1, 1'b1);
    check("R4 src1 unused", 1'b0);
    apply(5'd2, 1'b1, 5'd6, 1'b0, 5'd6, 1'b1, 1'b1);
    check("R4 src2 unused", 1'b0);
    apply(5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1);
    check("R5 register zero", 1'b0);
    apply(5'd8, 1'b1, 5'd8, 1'b1, 5'd8, 1'b1, 1'b0);
    check("R6 alu producer", 1'b0);
    apply(5'd11, 1'b1, 5'd11, 1'b1, 5'd11, 1'b1, 1'b1);
    check("R9 both sources", 1'b1);
    apply(5'd4, 1'b0, 5'd4, 1'b1, 5'd4, 1'b1, 1'b1);
    check("R9 masked plus live", 1'b1);

    // R8: load in execute, then the bubble takes its place.
    apply(5'd14, 1'b1, 5'd1, 1'b1, 5'd14, 1'b1, 1'b1);
    check("R8 first cycle stalls", 1'b1);
    apply(5'd14, 1'b1, 5'd1, 1'b1, 5'd14, 1'b0, 1'b0);
    check("R8 bubble cycle released", 1'b0);
    apply(5'd14, 1'b1, 5'd1, 1'b1, 5'd0, 1'b0, 1'b0);
    check("R8 bubble zeroed released", 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [4:0] s1, s2, d;
      logic u1, u2, rw, mr;
      s1 = 5'($urandom_range(0, 3));
      s2 = 5'($urandom_range(0, 3));
      d  = 5'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) d = 5'($urandom_range(0, 31));
      u1 = 1'($urandom_range(0, 1));
      u2 = 1'($urandom_range(0, 1));
      rw = 1'($urandom_range(0, 3) != 0);
      mr = 1'($urandom_range(0, 1));
      apply(s1, u1, s2, u2, d, rw, mr);
      check("R1 R2 R3 R4 R5 R6 random", model_stall(s1, u1, s2, u2, d, rw, mr));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule